// File: doc/BRIEF.md
# Integer Register File with Hardwired Zero Entry

This block is the general-purpose register storage of a small load/store processor core. It holds 32 integer registers, selected by a 5-bit index, and serves one instruction per cycle: two source operands are read at once through two independent read ports, and one result is written back through a single write port. The word width is 32 bits by default. The `XLEN` parameter switches it to 64 bits for a wider-word core.

Entry 0 is special. It has no storage at all and always reads as zero, and writes aimed at it are dropped without effect. The other 31 entries are plain storage that uses the full word width. Reads are combinational. A write lands on the rising clock edge. By default, a read of an entry being written in the same cycle returns the old contents, and the pipeline is expected to do any bypassing. The `WRITE_THRU` parameter enables an internal bypass instead. A synchronous reset clears entries 1 to 31.

Top module: `zreg_file`

## Requirements
- R1: The file has 32 entries addressed by a 5-bit index. Each of the two read ports returns, combinationally and independently of the other, the contents of the entry its index selects.
- R2: A read of index 0 returns all zeros on either port at all times, whatever has been written.
- R3: A write with index 0 has no effect: index 0 still reads zero, and entries 1 to 31 keep their contents.
- R4: With `wr_en` high and an index from 1 to 31, `wr_data` is stored on the rising clock edge. All `XLEN` bits are kept, and the value is visible from the next cycle on.
- R5: With `wr_en` low, no entry changes, whatever `wr_idx` and `wr_data` carry.
- R6: With `WRITE_THRU` = 0 (the default), a port that reads the entry being written in the same cycle returns the value held before that write.
- R7: With `rst` high at a rising edge, entries 1 to 31 are cleared to zero.
- R8: Both read ports may select the same entry in the same cycle, and both then return its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. Writes and reset act on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd_idx_a | input | 5 | Index for the first read port |
| rd_data_a | output | XLEN | Data from the first read port |
| rd_idx_b | input | 5 | Index for the second read port |
| rd_data_b | output | XLEN | Data from the second read port |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Index of the entry to write |
| wr_data | input | XLEN | Data to write |

## Verification
The bench sweeps every index on both ports with data patterns that differ for each entry and in their top and bottom bits. A decoder that is off by one, or a port wired to the wrong index, therefore returns another entry's pattern, and a narrowed store loses the high bits of an all-ones word. It writes nonzero data to index 0 and then reads index 0 and all the other entries. A design that gave entry 0 real storage would then return that data, and one that decoded the zero index wrongly would corrupt a neighbouring entry. It holds a read on the entry being written at that same moment and samples before the edge and after it, which exposes an unintended bypass or a missed write. It also checks that the reset clears every entry and that a write with the enable low changes nothing.

// File: rtl/zreg_file.sv
module zreg_file #(
  parameter int XLEN       = 32,
  parameter int IDXW       = 5,
  parameter bit WRITE_THRU = 1'b0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [IDXW-1:0] rd_idx_a,
  output logic [XLEN-1:0] rd_data_a,
  input  logic [IDXW-1:0] rd_idx_b,
  output logic [XLEN-1:0] rd_data_b,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [XLEN-1:0] wr_data
);
  localparam int NREG = 2 ** IDXW;

  logic [XLEN-1:0] regs [1:NREG-1];
  logic [XLEN-1:0] raw_a, raw_b;
  logic            wr_live;

  assign wr_live = wr_en && (wr_idx != '0);

  always_ff @(posedge clk) begin
    for (int i = 1; i < NREG; i++) begin
      if (rst)
        regs[i] <= '0;
      else if (wr_live && wr_idx == IDXW'(i))
        regs[i] <= wr_data;
    end
  end

  assign raw_a = (rd_idx_a == '0) ? '0 : regs[rd_idx_a];
  assign raw_b = (rd_idx_b == '0) ? '0 : regs[rd_idx_b];

  generate
    if (WRITE_THRU) begin : g_bypass
      assign rd_data_a = (wr_live && wr_idx == rd_idx_a) ? wr_data : raw_a;
      assign rd_data_b = (wr_live && wr_idx == rd_idx_b) ? wr_data : raw_b;
    end else begin : g_plain
      assign rd_data_a = raw_a;
      assign rd_data_b = raw_b;
    end
  endgenerate

  a_r2_zero_a: assert property (@(posedge clk) disable iff (rst)
    rd_idx_a == '0 |-> rd_data_a == '0);
  a_r2_zero_b: assert property (@(posedge clk) disable iff (rst)
    rd_idx_b == '0 |-> rd_data_b == '0);
  a_r4_write_lands_a: assert property (@(posedge clk) disable iff (rst)
    wr_en && wr_idx != '0 |=>
      (rd_idx_a != $past(wr_idx) || (WRITE_THRU && wr_en && wr_idx == rd_idx_a)
       || rd_data_a == $past(wr_data)));
  a_r4_write_lands_b: assert property (@(posedge clk) disable iff (rst)
    wr_en && wr_idx != '0 |=>
      (rd_idx_b != $past(wr_idx) || (WRITE_THRU && wr_en && wr_idx == rd_idx_b)
       || rd_data_b == $past(wr_data)));
  a_r7_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) && !(WRITE_THRU && wr_en) |-> rd_data_a == '0 && rd_data_b == '0);
endmodule

// File: tb/zreg_file_tb.sv
module zreg_file_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  rd_idx_a = '0, rd_idx_b = '0, wr_idx = '0;
  logic [31:0] rd_data_a, rd_data_b, wr_data = '0;
  logic        wr_en = 1'b0;

  logic [31:0] model [32];
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  zreg_file u_dut (
    .clk(clk), .rst(rst),
    .rd_idx_a(rd_idx_a), .rd_data_a(rd_data_a),
    .rd_idx_b(rd_idx_b), .rd_data_b(rd_data_b),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  function automatic logic [31:0] pat(input int i, input int k);
    return (32'(i) * 32'h0101_0101) ^ (32'(k) * 32'h9E37_79B9) ^ 32'h8000_0001;
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd_both(input string req, input int a, input int b);
    @(negedge clk);
    wr_en = 1'b0; rd_idx_a = 5'(a); rd_idx_b = 5'(b);
    #1;
    chk(req, rd_data_a, model[a]);
    chk(req, rd_data_b, model[b]);
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 5'(idx); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (idx != 0) model[idx] = d;
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < 32; i++) rd_both(req, i, 31 - i);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 32; i++) model[i] = '0;
  endtask

  initial begin
    #800000;
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    sweep("R7 reset state");

    for (int i = 0; i < 32; i++) wr(i, pat(i, 1));
    sweep("R1/R4 write sweep, pattern 1");
    for (int i = 0; i < 32; i++) rd_both("R8 same entry on both ports", i, i);

    wr(0, 32'hFFFF_FFFF);
    rd_both("R2 index 0 after write", 0, 0);
    sweep("R3 write to index 0 leaves others");

    for (int i = 31; i >= 0; i--) wr(i, ~pat(i, 2));
    sweep("R4 reverse-order sweep, pattern 2");

    wr(31, 32'hFFFF_FFFF);
    wr(1, 32'h8000_0000);
    rd_both("R4 full width", 31, 1);

    @(negedge clk);
    wr_en = 1'b0; wr_idx = 5'd9; wr_data = 32'hDEAD_BEEF;
    @(negedge clk);
    wr_idx = 5'd0;
    sweep("R5 disabled write");

    @(negedge clk);
    wr_en = 1'b1; wr_idx = 5'd7; wr_data = 32'h1234_5678;
    rd_idx_a = 5'd7; rd_idx_b = 5'd7;
    #1;
    chk("R6 read during write port a", rd_data_a, model[7]);
    chk("R6 read during write port b", rd_data_b, model[7]);
    @(negedge clk);
    wr_en = 1'b0;
    model[7] = 32'h1234_5678;
    #1;
    chk("R4 value after edge port a", rd_data_a, model[7]);
    chk("R8 value after edge port b", rd_data_b, model[7]);

    do_reset();
    sweep("R7 reset after writes");

    for (int i = 0; i < 32; i++) wr(i, pat(i, 3) ^ 32'h5A5A_A5A5);
    for (int i = 0; i < 32; i++) rd_both("R1 independent ports", i, (i * 7) % 32);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule